// File: doc/BRIEF.md
# Supervisory Reset Timeout Generator

This block turns two "system not ready" indications into one clean system reset. One is a supply-good flag from an external comparator, already synchronized to the block clock. The other is an active-low manual request from a push-button, a watchdog or another supervisor. While either indication is bad, reset stays asserted. Once both are good, a recovery counter runs for a fixed number of timebase ticks, and only then is reset released.

The counter is cleared whenever a cause is present, so each reset episode lasts at least the full recovery interval. Any disturbance during recovery starts the interval again. The recovery length is `RECOVERY_TICKS` pulses of the one-cycle `tick` input. This lets a real design tie `tick` to a millisecond strobe, while simulation can use tick-every-cycle and a short count.

Both polarities of reset are driven from one register. The parameter `HIGH_ONLY` selects a build in which the active-high output is the only live reset and the active-low pin sits at its inactive level.

Top module: `reset_timeout_gen`

## Requirements
- R1: When `supply_ok` is low ahead of a clock edge, `rst` is 1 after that edge, and it stays 1 while `supply_ok` remains low.
- R2: When `man_rst_n` goes low, it passes through a two-flop synchronizer. `rst` becomes 1 on the third edge after the change and stays 1 while the input remains low.
- R3: With `tick` high every cycle, after `supply_ok` returns high (and `man_rst_n` is high), `rst` stays 1 for exactly `RECOVERY_TICKS` edges and reads 0 after edge `RECOVERY_TICKS`+1.
- R4: With `tick` high every cycle, after `man_rst_n` returns high (and `supply_ok` is high), `rst` reads 0 after edge `RECOVERY_TICKS`+3.
- R5: A loss of supply during recovery clears the counter. Release then comes a full `RECOVERY_TICKS`+1 edges after the supply is good again.
- R6: A cause of any length, including a single cycle, produces a reset of at least the full recovery interval.
- R7: The recovery counter advances only on edges where `tick` is 1. Release comes on the edge after the one that carries the `RECOVERY_TICKS`-th tick seen with no cause present. With `tick` held at 0, reset never releases.
- R8: With `HIGH_ONLY`=0, `rst_n` is always the complement of `rst`. With `HIGH_ONLY`=1, `rst` behaves the same and `rst_n` stays 1.
- R9: `por` high forces `rst` to 1 and clears the counter on the next edge. After `por` falls with both sources good, release follows `RECOVERY_TICKS`+1 edges later. The synchronizer comes out of `por` at the deasserted level, so an unused manual input tied high does not extend this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Synchronous power-on reset, active high |
| supply_ok | input | 1 | Synchronized supply-good flag, 1 = supply above threshold |
| man_rst_n | input | 1 | Asynchronous manual reset request, active low, tie high if unused |
| tick | input | 1 | One-cycle timebase strobe that advances the recovery count |
| rst_n | output | 1 | Active-low system reset (held 1 when `HIGH_ONLY`=1) |
| rst | output | 1 | Active-high system reset |

## Verification
A supply fault shows at the outputs one edge after it is applied. A manual request takes three edges, because of the synchronizer and the output register. Release comes `RECOVERY_TICKS`+1 edges after the supply returns, and `RECOVERY_TICKS`+3 edges after the manual input returns. The bench drives inputs one time unit after an edge and samples one time unit after each later edge, so the edge count is exact. It compares every sampled cycle of a stimulus window against the edge index at which the change is due. With a sparse tick, the bench counts the ticks it drove on edges with no cause present and expects release on the edge after the count reaches the recovery length.

// File: rtl/reset_timeout_gen.sv
module reset_timeout_gen #(
  parameter int RECOVERY_TICKS = 200,
  parameter bit HIGH_ONLY      = 1'b0
) (
  input  logic clk,
  input  logic por,
  input  logic supply_ok,
  input  logic man_rst_n,
  input  logic tick,
  output logic rst_n,
  output logic rst
);
  localparam int CW = $clog2(RECOVERY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOVERY_TICKS);

  logic          m_meta, m_sync;
  logic [CW-1:0] cnt;
  logic          act;
  logic          cause, done;

  assign cause = !supply_ok || !m_sync;
  assign done  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (por) begin
      m_meta <= 1'b1;
      m_sync <= 1'b1;
      cnt    <= '0;
      act    <= 1'b1;
    end else begin
      m_meta <= man_rst_n;
      m_sync <= m_meta;
      if (cause)             cnt <= '0;
      else if (tick && !done) cnt <= cnt + 1'b1;
      act <= cause || !done;
    end
  end

  assign rst = act;

  generate
    if (HIGH_ONLY) begin : g_high_only
      assign rst_n = 1'b1;
    end else begin : g_both
      assign rst_n = !act;
    end
  endgenerate

  assert_supply_bad_R1: assert property (@(posedge clk) disable iff (por)
    !supply_ok |=> rst);

  assert_manual_low_R2: assert property (@(posedge clk) disable iff (por)
    !m_sync |=> rst);

  assert_release_full_R3: assert property (@(posedge clk) disable iff (por)
    $fell(act) |-> ($past(cnt) == LAST));

  assert_cleared_on_cause_R5: assert property (@(posedge clk) disable iff (por)
    cause |=> (cnt == '0));

  assert_min_hold_R6: assert property (@(posedge clk) disable iff (por)
    $rose(act) |=> act);

  assert_tick_only_R7: assert property (@(posedge clk) disable iff (por)
    (!tick && !cause) |=> $stable(cnt));

  assert_polarity_R8: assert property (@(posedge clk) disable iff (por)
    HIGH_ONLY ? (rst_n == 1'b1) : (rst_n == !rst));

  assert_por_forces_R9: assert property (@(posedge clk)
    por |=> (rst && cnt == '0));
endmodule

// File: tb/sim_reset_timeout_gen.sv
module sim_reset_timeout_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 1'b0;
  logic por, supply_ok, man_rst_n, tick;
  logic rst_n0, rst0, rst_n1, rst1;
  int   nvec = 0;
  int   nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_timeout_gen #(.RECOVERY_TICKS(N), .HIGH_ONLY(1'b0)) u0 (
    .clk(clk), .por(por), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .tick(tick), .rst_n(rst_n0), .rst(rst0));

  reset_timeout_gen #(.RECOVERY_TICKS(N), .HIGH_ONLY(1'b1)) u1 (
    .clk(clk), .por(por), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .tick(tick), .rst_n(rst_n1), .rst(rst1));

  task automatic chk(input logic act_v, input logic exp_v, input string req);
    nvec++;
    if (act_v !== exp_v) begin
      nbad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act_v, exp_v);
    end
  endtask

  task automatic sample(input logic exp_rst, input string req);
    chk(rst0, exp_rst, req);
    chk(rst_n0, !exp_rst, "R8");
    chk(rst1, exp_rst, "R8");
    chk(rst_n1, 1'b1, "R8");
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_release(input int edges, input string req);
    for (int k = 1; k <= edges + 1; k++) begin
      edge1();
      sample(k < edges, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    por = 1'b1; supply_ok = 1'b0; man_rst_n = 1'b1; tick = 1'b1;
    edge1(); sample(1'b1, "R9");
    edge1(); sample(1'b1, "R9");
    supply_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin edge1(); sample(1'b1, "R9"); end
    por = 1'b0;
    expect_release(N + 1, "R9");

    // R1 / R3: supply fault then return
    supply_ok = 1'b0;
    for (int i = 0; i < 4; i++) begin edge1(); sample(1'b1, "R1"); end
    supply_ok = 1'b1;
    expect_release(N + 1, "R3");

    // R6: short supply faults of several lengths
    for (int len = 1; len <= 4; len++) begin
      supply_ok = 1'b0;
      for (int i = 0; i < len; i++) begin edge1(); sample(1'b1, "R6"); end
      supply_ok = 1'b1;
      expect_release(N + 1, "R6");
    end

    // R2 / R4: manual request through the synchronizer
    man_rst_n = 1'b0;
    edge1(); sample(1'b0, "R2");
    edge1(); sample(1'b0, "R2");
    for (int i = 0; i < 4; i++) begin edge1(); sample(1'b1, "R2"); end
    man_rst_n = 1'b1;
    expect_release(N + 3, "R4");

    for (int len = 2; len <= 4; len++) begin
      man_rst_n = 1'b0;
      for (int i = 0; i < len; i++) edge1();
      man_rst_n = 1'b1;
      expect_release(N + 3, "R4");
    end

    // R5: supply drop in the middle of recovery restarts the interval
    supply_ok = 1'b0;
    edge1(); edge1();
    supply_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin edge1(); sample(1'b1, "R5"); end
    supply_ok = 1'b0;
    edge1(); sample(1'b1, "R5");
    supply_ok = 1'b1;
    expect_release(N + 1, "R5");

    // R7: no ticks, no release; then sparse ticks
    supply_ok = 1'b0;
    edge1(); edge1();
    supply_ok = 1'b1;
    tick = 1'b0;
    for (int i = 0; i < 3 * N; i++) begin edge1(); sample(1'b1, "R7"); end
    begin
      int tc;
      tc = 0;
      for (int k = 1; k <= 3 * N + 4; k++) begin
        logic t;
        t = (k % 3 == 0);
        tick = t;
        edge1();
        sample(!(tc >= N), "R7");
        if (t) tc++;
      end
    end
    tick = 1'b1;

    // R9: por in the middle of operation
    por = 1'b1;
    edge1(); sample(1'b1, "R9");
    por = 1'b0;
    expect_release(N + 1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule